// File: doc/BRIEF.md
# Superscalar Register Rename Stage

This block renames a group of instructions in a single cycle. Each slot of the group carries two source logical registers, one destination logical register and a fresh physical tag for that destination, handed in from an external allocator. A mapping table with one entry per logical register supplies the current physical register for every operand. A comparator network runs at the same time and looks for sources that an older slot in the same group overwrites. When it finds one, a per-operand multiplexer replaces the table value with that older slot's new tag.

The renamed group leaves through a registered output one cycle after a valid group arrives. On the same clock edge the table takes in every destination of the group. For each slot the block also reports the mapping that the destination held before this slot claimed it, so a later stage can free that tag. Slot 0 is the oldest instruction in the group. Slot k sits in bits [k*W +: W] of every flat bus, where W is the field width.

Top module: `rn_rename`

## Requirements
- R1: After reset, logical register i maps to physical tag i for every i, and ren_valid is low.
- R2: ren_valid is high in the cycle after a clock edge that samples grp_valid high, and low after an edge that samples it low. All renamed fields appear with this one-cycle latency.
- R3: A source that no older slot in the group writes receives the table mapping as it stood before the group's own writes.
- R4: A source whose logical register equals the destination of an older slot in the same group receives that slot's new tag. Slot 0 is never forwarded, and a slot's own destination does not affect its sources.
- R5: When more than one older slot writes a source's logical register, the closest preceding slot supplies the tag.
- R6: ren_dst for each slot equals the new tag presented with that slot.
- R7: ren_prev for each slot is the mapping its destination held just before that slot. This is the closest older slot's new tag when an older slot in the group writes the same register, and the table value otherwise.
- R8: A valid group updates the table at its clock edge, and the next group sees the update. When several slots name the same destination, the youngest slot's tag is kept.
- R9: A group presented with grp_valid low leaves the table unchanged.
- R10: Logical register 0 is renamed like any other register, with no hardwired value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | Group present this cycle |
| grp_src_a | input | GROUP*5 | First source logical register per slot |
| grp_src_b | input | GROUP*5 | Second source logical register per slot |
| grp_dst | input | GROUP*5 | Destination logical register per slot |
| grp_new_tag | input | GROUP*7 | Newly allocated physical tag per slot |
| ren_valid | output | 1 | Renamed group valid |
| ren_src_a | output | GROUP*7 | Physical tag for first source |
| ren_src_b | output | GROUP*7 | Physical tag for second source |
| ren_dst | output | GROUP*7 | Physical tag for destination |
| ren_prev | output | GROUP*7 | Previous mapping of destination |

## Verification
Two things can happen in the same cycle: a table read for a source, and a same-group override of that source by an older slot. The same cycle also holds the table write by a group and the lookups of the group that follows it. The bench provokes both by drawing logical registers from a narrow range most of the time, which makes collisions among the slots of a group and between back-to-back groups frequent. Directed groups add all-same destinations, register 0 and invalid groups. Each output is compared with a bench mapping model that resolves the closest older writer and applies the writes youngest-last after each valid group.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int unsigned DEF_GROUP  = 4;
    localparam int unsigned DEF_LREGS  = 32;
    localparam int unsigned DEF_PTAG_W = 7;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int unsigned LREGS  = rn_pkg::DEF_LREGS,
    parameter int unsigned PTAG_W = rn_pkg::DEF_PTAG_W,
    parameter int unsigned WPORTS = rn_pkg::DEF_GROUP,
    parameter int unsigned RPORTS = 3 * rn_pkg::DEF_GROUP,
    localparam int unsigned LREG_W = $clog2(LREGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [RPORTS*LREG_W-1:0]   rd_idx,
    output logic [RPORTS*PTAG_W-1:0]   rd_tag,
    input  logic [WPORTS-1:0]          wr_en,
    input  logic [WPORTS*LREG_W-1:0]   wr_idx,
    input  logic [WPORTS*PTAG_W-1:0]   wr_tag
);
    logic [PTAG_W-1:0] map_q [LREGS];
    logic [PTAG_W-1:0] map_d [LREGS];

    // read ports see the state before this cycle's writes
    for (genvar r = 0; r < RPORTS; r++) begin : g_rd
        assign rd_tag[r*PTAG_W +: PTAG_W] = map_q[rd_idx[r*LREG_W +: LREG_W]];
    end

    // ascending slot order: the youngest writer lands last
    always_comb begin
        for (int i = 0; i < LREGS; i++) map_d[i] = map_q[i];
        for (int k = 0; k < WPORTS; k++) begin
            if (wr_en[k]) map_d[wr_idx[k*LREG_W +: LREG_W]] = wr_tag[k*PTAG_W +: PTAG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LREGS; i++) map_q[i] <= PTAG_W'(i);
        end else begin
            for (int i = 0; i < LREGS; i++) map_q[i] <= map_d[i];
        end
    end
endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check #(
    parameter int unsigned GROUP  = rn_pkg::DEF_GROUP,
    parameter int unsigned LREG_W = 5,
    parameter int unsigned PTAG_W = rn_pkg::DEF_PTAG_W,
    parameter int unsigned SLOT   = 0
) (
    input  logic [LREG_W-1:0]        lreg,
    input  logic [GROUP*LREG_W-1:0]  grp_dst,
    input  logic [GROUP*PTAG_W-1:0]  grp_new_tag,
    input  logic [PTAG_W-1:0]        table_tag,
    output logic [PTAG_W-1:0]        phys_tag
);
    logic              hit;
    logic [PTAG_W-1:0] fwd_tag;

    // scan older slots oldest first, so the closest one overrides
    always_comb begin
        hit     = 1'b0;
        fwd_tag = '0;
        for (int j = 0; j < GROUP; j++) begin
            if (j < SLOT && grp_dst[j*LREG_W +: LREG_W] == lreg) begin
                hit     = 1'b1;
                fwd_tag = grp_new_tag[j*PTAG_W +: PTAG_W];
            end
        end
    end

    assign phys_tag = hit ? fwd_tag : table_tag;
endmodule

// File: rtl/rn_rename.sv
module rn_rename #(
    parameter int unsigned GROUP  = rn_pkg::DEF_GROUP,
    parameter int unsigned LREGS  = rn_pkg::DEF_LREGS,
    parameter int unsigned PTAG_W = rn_pkg::DEF_PTAG_W,
    localparam int unsigned LREG_W = $clog2(LREGS),
    localparam int unsigned NRD    = 3 * GROUP
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      grp_valid,
    input  logic [GROUP*LREG_W-1:0]   grp_src_a,
    input  logic [GROUP*LREG_W-1:0]   grp_src_b,
    input  logic [GROUP*LREG_W-1:0]   grp_dst,
    input  logic [GROUP*PTAG_W-1:0]   grp_new_tag,
    output logic                      ren_valid,
    output logic [GROUP*PTAG_W-1:0]   ren_src_a,
    output logic [GROUP*PTAG_W-1:0]   ren_src_b,
    output logic [GROUP*PTAG_W-1:0]   ren_dst,
    output logic [GROUP*PTAG_W-1:0]   ren_prev
);
    typedef struct packed {
        logic                    vld;
        logic [GROUP*PTAG_W-1:0] a;
        logic [GROUP*PTAG_W-1:0] b;
        logic [GROUP*PTAG_W-1:0] d;
        logic [GROUP*PTAG_W-1:0] p;
    } out_t;

    out_t out_d, out_q;

    logic [NRD*LREG_W-1:0]   rd_idx;
    logic [NRD*PTAG_W-1:0]   rd_tag;
    logic [GROUP*PTAG_W-1:0] tag_a, tag_b, tag_p;

    // read port layout: [0,G) source a, [G,2G) source b, [2G,3G) destination
    assign rd_idx = {grp_dst, grp_src_b, grp_src_a};

    rn_map_table #(
        .LREGS(LREGS), .PTAG_W(PTAG_W), .WPORTS(GROUP), .RPORTS(NRD)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .rd_tag (rd_tag),
        .wr_en  ({GROUP{grp_valid}}),
        .wr_idx (grp_dst),
        .wr_tag (grp_new_tag)
    );

    for (genvar s = 0; s < GROUP; s++) begin : g_slot
        rn_dep_check #(.GROUP(GROUP), .LREG_W(LREG_W), .PTAG_W(PTAG_W), .SLOT(s)) u_a (
            .lreg        (grp_src_a[s*LREG_W +: LREG_W]),
            .grp_dst     (grp_dst),
            .grp_new_tag (grp_new_tag),
            .table_tag   (rd_tag[s*PTAG_W +: PTAG_W]),
            .phys_tag    (tag_a[s*PTAG_W +: PTAG_W])
        );
        rn_dep_check #(.GROUP(GROUP), .LREG_W(LREG_W), .PTAG_W(PTAG_W), .SLOT(s)) u_b (
            .lreg        (grp_src_b[s*LREG_W +: LREG_W]),
            .grp_dst     (grp_dst),
            .grp_new_tag (grp_new_tag),
            .table_tag   (rd_tag[(GROUP+s)*PTAG_W +: PTAG_W]),
            .phys_tag    (tag_b[s*PTAG_W +: PTAG_W])
        );
        rn_dep_check #(.GROUP(GROUP), .LREG_W(LREG_W), .PTAG_W(PTAG_W), .SLOT(s)) u_p (
            .lreg        (grp_dst[s*LREG_W +: LREG_W]),
            .grp_dst     (grp_dst),
            .grp_new_tag (grp_new_tag),
            .table_tag   (rd_tag[(2*GROUP+s)*PTAG_W +: PTAG_W]),
            .phys_tag    (tag_p[s*PTAG_W +: PTAG_W])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = grp_valid;
        if (grp_valid) begin
            out_d.a = tag_a;
            out_d.b = tag_b;
            out_d.d = grp_new_tag;
            out_d.p = tag_p;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ren_valid = out_q.vld;
    assign ren_src_a = out_q.a;
    assign ren_src_b = out_q.b;
    assign ren_dst   = out_q.d;
    assign ren_prev  = out_q.p;
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int unsigned GROUP  = rn_pkg::DEF_GROUP,
    parameter int unsigned LREG_W = 5,
    parameter int unsigned PTAG_W = rn_pkg::DEF_PTAG_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     grp_valid,
    input logic [GROUP*LREG_W-1:0]  grp_src_a,
    input logic [GROUP*LREG_W-1:0]  grp_src_b,
    input logic [GROUP*LREG_W-1:0]  grp_dst,
    input logic [GROUP*PTAG_W-1:0]  grp_new_tag,
    input logic                     ren_valid,
    input logic [GROUP*PTAG_W-1:0]  ren_src_a,
    input logic [GROUP*PTAG_W-1:0]  ren_src_b,
    input logic [GROUP*PTAG_W-1:0]  ren_dst
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |=> ren_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid |=> !ren_valid);

    assert_dst_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |=> ren_dst == $past(grp_new_tag));

    if (GROUP > 1) begin : g_fwd
        // slot 1 has exactly one older slot, so a match must forward slot 0's tag
        assert_fwd_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_valid && grp_src_a[LREG_W +: LREG_W] == grp_dst[0 +: LREG_W])
            |=> ren_src_a[PTAG_W +: PTAG_W] == $past(grp_new_tag[0 +: PTAG_W]));

        assert_fwd_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_valid && grp_src_b[LREG_W +: LREG_W] == grp_dst[0 +: LREG_W])
            |=> ren_src_b[PTAG_W +: PTAG_W] == $past(grp_new_tag[0 +: PTAG_W]));
    end
endmodule

bind rn_rename rn_rename_chk #(.GROUP(GROUP), .LREG_W(LREG_W), .PTAG_W(PTAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_valid   (grp_valid),
    .grp_src_a   (grp_src_a),
    .grp_src_b   (grp_src_b),
    .grp_dst     (grp_dst),
    .grp_new_tag (grp_new_tag),
    .ren_valid   (ren_valid),
    .ren_src_a   (ren_src_a),
    .ren_src_b   (ren_src_b),
    .ren_dst     (ren_dst)
);

// File: tb/sim_rn_rename.sv
`timescale 1ns/1ps
module sim_rn_rename;
    localparam int G  = 4;
    localparam int LW = 5;
    localparam int PW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_valid = 1'b0;
    logic [G*LW-1:0] grp_src_a = '0, grp_src_b = '0, grp_dst = '0;
    logic [G*PW-1:0] grp_new_tag = '0;
    logic ren_valid;
    logic [G*PW-1:0] ren_src_a, ren_src_b, ren_dst, ren_prev;

    int total = 0;
    int bad = 0;
    logic [PW-1:0] model [32];

    always #2.5 clk = ~clk;

    rn_rename u0 (
        .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid),
        .grp_src_a(grp_src_a), .grp_src_b(grp_src_b), .grp_dst(grp_dst),
        .grp_new_tag(grp_new_tag), .ren_valid(ren_valid),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_dst(ren_dst), .ren_prev(ren_prev)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // mapping seen by slot s for register r: closest older writer, else model
    function automatic int resolve(input logic [4:0] r, input int s,
                                   input logic [4:0] d[G], input logic [6:0] t[G]);
        int e = model[r];
        for (int j = 0; j < s; j++) if (d[j] == r) e = t[j];
        return e;
    endfunction

    function automatic string src_req(input logic [4:0] r, input int s, input logic [4:0] d[G]);
        int n = 0;
        for (int j = 0; j < s; j++) if (d[j] == r) n++;
        return (n == 0) ? "R3" : ((n == 1) ? "R4" : "R5");
    endfunction

    task automatic run_group(input bit v, input logic [4:0] sa[G], input logic [4:0] sb[G],
                             input logic [4:0] d[G], input logic [6:0] t[G]);
        int ea[G], eb[G], ep[G];
        string ra[G], rb[G];
        grp_valid = v;
        for (int s = 0; s < G; s++) begin
            grp_src_a[s*LW +: LW] = sa[s];
            grp_src_b[s*LW +: LW] = sb[s];
            grp_dst[s*LW +: LW]   = d[s];
            grp_new_tag[s*PW +: PW] = t[s];
            ea[s] = resolve(sa[s], s, d, t);
            eb[s] = resolve(sb[s], s, d, t);
            ep[s] = resolve(d[s], s, d, t);
            ra[s] = src_req(sa[s], s, d);
            rb[s] = src_req(sb[s], s, d);
        end
        if (v) for (int s = 0; s < G; s++) model[d[s]] = t[s];
        @(negedge clk);
        chk("R2", int'(ren_valid), int'(v));
        if (v) begin
            for (int s = 0; s < G; s++) begin
                chk(ra[s], int'(ren_src_a[s*PW +: PW]), ea[s]);
                chk(rb[s], int'(ren_src_b[s*PW +: PW]), eb[s]);
                chk("R6", int'(ren_dst[s*PW +: PW]), int'(t[s]));
                chk("R7", int'(ren_prev[s*PW +: PW]), ep[s]);
            end
        end
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [4:0] sa[G], sb[G], d[G];
        logic [6:0] t[G];
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) model[i] = PW'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(ren_valid), 0);

        // R1: identity mapping after reset, read with an invalid-write-free group
        for (int s = 0; s < G; s++) begin
            sa[s] = 5'(s + 20); sb[s] = 5'(s + 24); d[s] = 5'(s + 28); t[s] = 7'(100 + s);
        end
        run_group(1'b1, sa, sb, d, t);
        for (int s = 0; s < G; s++) begin
            sa[s] = 5'(s + 8); sb[s] = 5'(s + 12); d[s] = 5'(s + 28); t[s] = 7'(110 + s);
        end
        run_group(1'b1, sa, sb, d, t);
        chk("R1", int'(ren_src_a[PW +: PW]), 9);

        // R8: all slots write register 5, youngest kept
        for (int s = 0; s < G; s++) begin
            sa[s] = 5'd5; sb[s] = 5'd5; d[s] = 5'd5; t[s] = 7'(40 + s);
        end
        run_group(1'b1, sa, sb, d, t);
        for (int s = 0; s < G; s++) begin
            sa[s] = 5'd5; sb[s] = 5'd1; d[s] = 5'(16 + s); t[s] = 7'(60 + s);
        end
        run_group(1'b1, sa, sb, d, t);
        chk("R8", int'(ren_src_a[0 +: PW]), 40 + G - 1);

        // R9: invalid group must not touch register 6
        for (int s = 0; s < G; s++) begin
            sa[s] = 5'd6; sb[s] = 5'd6; d[s] = 5'd6; t[s] = 7'(70 + s);
        end
        run_group(1'b0, sa, sb, d, t);
        for (int s = 0; s < G; s++) begin
            sa[s] = 5'd6; sb[s] = 5'd6; d[s] = 5'(16 + s); t[s] = 7'(80 + s);
        end
        run_group(1'b1, sa, sb, d, t);
        chk("R9", int'(ren_src_b[0 +: PW]), 6);

        // R10: register 0 renamed and forwarded as an ordinary register
        for (int s = 0; s < G; s++) begin
            sa[s] = 5'd0; sb[s] = 5'd0; d[s] = 5'd0; t[s] = 7'(90 + s);
        end
        run_group(1'b1, sa, sb, d, t);
        chk("R10", int'(ren_src_a[PW +: PW]), 90);
        for (int s = 0; s < G; s++) begin
            sa[s] = 5'd0; sb[s] = 5'd2; d[s] = 5'(16 + s); t[s] = 7'(95 + s);
        end
        run_group(1'b1, sa, sb, d, t);
        chk("R10", int'(ren_src_a[0 +: PW]), 90 + G - 1);

        // R5: slots 0 and 1 write 9, slot 3 reads 9
        sa = '{5'd3, 5'd4, 5'd9, 5'd9}; sb = '{5'd9, 5'd9, 5'd7, 5'd9};
        d  = '{5'd9, 5'd9, 5'd11, 5'd12}; t = '{7'd21, 7'd22, 7'd23, 7'd24};
        run_group(1'b1, sa, sb, d, t);
        chk("R5", int'(ren_src_a[3*PW +: PW]), 22);

        // random groups with frequent collisions
        for (int n = 0; n < 400; n++) begin
            bit v = ($urandom % 8) != 0;
            for (int s = 0; s < G; s++) begin
                bit narrow = ($urandom % 4) != 0;
                sa[s] = narrow ? 5'($urandom % 6) : 5'($urandom);
                sb[s] = narrow ? 5'($urandom % 6) : 5'($urandom);
                d[s]  = narrow ? 5'($urandom % 6) : 5'($urandom);
                t[s]  = 7'($urandom);
            end
            run_group(v, sa, sb, d, t);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule